// File: doc/BRIEF.md
# Reloadable Timer/Event Counter with Pulse-Width Capture

The block is a 16-bit up-counter with a 16-bit reload value, set up through a small byte-wide register bus. A three-bit mode field picks the count source. Four timer modes each count on their own clock-enable input: system tick, system tick divided by four, real-time tick and A/D tick. An event mode counts selected transitions of an external pin. A capture mode measures how long the pin stays at one level. When the counter steps past its all-ones value, it reloads from the reload register and raises an interrupt flag. Each such wrap also toggles a divided-frequency output.

Software stops the counter and writes the reload value, which then loads the counter as well. It then writes the control byte with the run bit set. In capture mode the block starts counting on the chosen transition. It stops on the opposite transition, drops the run bit by itself, and leaves the measured width in the counter for software to read.

Top module: `evt_timer`

## Requirements
- R1: After reset the control byte, the reload value and the count all read 0. The flag, interrupt request and divider output are low.
- R2: The bus map is: address 0 control, 1 reload low byte, 2 reload high byte, 3 count low byte, 4 count high byte. In the control byte, bits 7:5 are the mode, bit 3 is the edge select and bit 4 is run. Bits 2:0 always read 0.
- R3: With run at 1, the count rises by one on each enable of the selected source. Mode 000 uses sysTick, 001 uses div4Tick, 010 uses rtcTick and 011 uses adcTick. Modes 110 and 111, or run at 0, leave the count unchanged. Outside mode 101, run changes only on a control write.
- R4: A count step taken at FFFFh loads the reload value and sets tmrFlag on the same edge. A pulse on flagAck clears the flag.
- R5: A reload-register byte write with run at 0 also writes that byte of the count. With run at 1 it changes only the reload value, and the count is unaffected until its next wrap.
- R6: Mode 100 counts one step per active transition of extIn. Edge select 0 means low-to-high and 1 means high-to-low. The opposite transition does not count.
- R7: In mode 101 with run set, counting on div4Tick starts after an active transition and goes on until the opposite transition. The result equals the number of clock edges the pin held the active level while div4Tick was high. Run then reads 0 and the count is held.
- R8: After a capture completes, further pin transitions leave the count unchanged. Setting run while the pin already sits at its active level does not start a capture; only a fresh active transition does.
- R9: irqReq is high exactly when tmrFlag is high and irqEnable is high. Wraps with irqEnable low still set tmrFlag.
- R10: A divider state toggles on every wrap. pfdOut shows that state when pfdEnable is high and is low otherwise.
- R11: A bus read of the count high byte blocks the count step in that cycle.
- R12: extIn passes through two synchronizer flops. In mode 100, a transition applied before clock edge k shows in the count after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| sysTick | input | 1 | System clock enable |
| div4Tick | input | 1 | System clock divided by 4 enable |
| rtcTick | input | 1 | Real-time clock enable |
| adcTick | input | 1 | A/D clock enable |
| extIn | input | 1 | External event / capture pin (asynchronous) |
| irqEnable | input | 1 | Interrupt request enable |
| pfdEnable | input | 1 | Divider output enable |
| flagAck | input | 1 | Clears the interrupt flag |
| tmrFlag | output | 1 | Wrap interrupt flag |
| irqReq | output | 1 | Gated interrupt request |
| pfdOut | output | 1 | Divided-frequency output |

## Verification
Register writes and tick enables act on the next clock edge, so a count stepped by a tick is visible one cycle after the tick. Pin transitions pass three registers before the count moves. The synchronizer adds two, and the edge-detect stage's effect lands on the edge after those two. Capture results and the auto-cleared run bit therefore settle two edges after the releasing transition. The driver only queues an expectation after waiting out these latencies. The monitor compares read data on the falling edge of the cycle in which the read is driven. The latency and read-blocking checks step through consecutive cycles to pin down the exact edge.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_PL_LO  = 3'd1;
  localparam logic [2:0] ADDR_PL_HI  = 3'd2;
  localparam logic [2:0] ADDR_CNT_LO = 3'd3;
  localparam logic [2:0] ADDR_CNT_HI = 3'd4;

  typedef enum logic [2:0] {
    MODE_SYS  = 3'd0,
    MODE_SYS4 = 3'd1,
    MODE_RTC  = 3'd2,
    MODE_ADC  = 3'd3,
    MODE_EVT  = 3'd4,
    MODE_PWM  = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } mode_e;

  typedef struct packed {
    logic inc;      // count step this cycle
    logic wrap;     // count step at all-ones
    logic plWrLo;   // reload low byte write
    logic plWrHi;   // reload high byte write
    logic cntLoad;  // reload writes also reach the count
  } strobe_t;
endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWe,
  input  logic          busRe,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic          sysTick,
  input  logic          div4Tick,
  input  logic          rtcTick,
  input  logic          adcTick,
  input  logic          extIn,
  input  logic          cntAtMax,
  output strobe_t       stb,
  output logic [DW-1:0] ctrlRd
);
  typedef enum logic {PW_WAIT, PW_MEAS} pwPhase_e;

  mode_e    mode;
  logic     edgeSel, run;
  pwPhase_e phase;

  // external pin synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  logic extS, extPrev;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) syncQ <= rstN ? extIn : 1'b0;
    end else begin : g_syncN
      always_ff @(posedge clk)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extIn};
    end
  endgenerate
  assign extS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk)
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extS;

  logic riseE, fallE, activeE, returnE;
  assign riseE   = extS & ~extPrev;
  assign fallE   = ~extS & extPrev;
  assign activeE = edgeSel ? fallE : riseE;
  assign returnE = edgeSel ? riseE : fallE;

  logic ctrlWr, hiRead, tickSel;
  assign ctrlWr = busWe && (busAddr == ADDR_CTRL);
  assign hiRead = busRe && (busAddr == ADDR_CNT_HI);

  always_comb begin
    unique case (mode)
      MODE_SYS:  tickSel = sysTick;
      MODE_SYS4: tickSel = div4Tick;
      MODE_RTC:  tickSel = rtcTick;
      MODE_ADC:  tickSel = adcTick;
      MODE_EVT:  tickSel = activeE;
      MODE_PWM:  tickSel = (phase == PW_MEAS) && div4Tick;
      default:   tickSel = 1'b0;
    endcase
  end

  always_comb begin
    stb.inc     = run && tickSel && !hiRead;
    stb.wrap    = stb.inc && cntAtMax;
    stb.plWrLo  = busWe && (busAddr == ADDR_PL_LO);
    stb.plWrHi  = busWe && (busAddr == ADDR_PL_HI);
    stb.cntLoad = !run;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_SYS;
      edgeSel <= 1'b0;
      run     <= 1'b0;
    end else if (ctrlWr) begin
      mode    <= mode_e'(busWdata[7:5]);
      run     <= busWdata[4];
      edgeSel <= busWdata[3];
    end else if (mode == MODE_PWM && phase == PW_MEAS && returnE) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrlWr || !run || mode != MODE_PWM) phase <= PW_WAIT;
    else if (phase == PW_WAIT && activeE)             phase <= PW_MEAS;
    else if (phase == PW_MEAS && returnE)             phase <= PW_WAIT;
  end

  assign ctrlRd = {mode, run, edgeSel, 3'b000};

  AST_PWM_AUTOSTOP: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PW_MEAS && returnE && !ctrlWr) |=> !run); // R7
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_PWM && run && !ctrlWr) |=> run); // R3
  AST_NO_STEP_ON_HIREAD: assert property (@(posedge clk) disable iff (!rstN)
    hiRead |-> !stb.inc); // R11
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [DW-1:0]    wrByte,
  input  logic             flagAck,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] plQ,
  output logic             cntAtMax,
  output logic             tmrFlag,
  output logic             pfdTgl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign cntAtMax = (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      plQ  <= '0;
    end else begin
      if (stb.wrap)     cntQ <= plQ;
      else if (stb.inc) cntQ <= cntQ + 1'b1;
      if (stb.plWrLo) begin
        plQ[DW-1:0] <= wrByte;
        if (stb.cntLoad) cntQ[DW-1:0] <= wrByte;
      end
      if (stb.plWrHi) begin
        plQ[CNT_W-1:DW] <= wrByte;
        if (stb.cntLoad) cntQ[CNT_W-1:DW] <= wrByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrFlag <= 1'b0;
      pfdTgl  <= 1'b0;
    end else begin
      if (stb.wrap)    tmrFlag <= 1'b1;
      else if (flagAck) tmrFlag <= 1'b0;
      if (stb.wrap)    pfdTgl  <= ~pfdTgl;
    end
  end

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrap && !stb.plWrLo && !stb.plWrHi) |=> cntQ == $past(plQ)); // R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrap |=> tmrFlag); // R4
  AST_PFD_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrap |=> $stable(pfdTgl)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.inc && !stb.plWrLo && !stb.plWrHi) |=> $stable(cntQ)); // R3
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic       busRe,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       sysTick,
  input  logic       div4Tick,
  input  logic       rtcTick,
  input  logic       adcTick,
  input  logic       extIn,
  input  logic       irqEnable,
  input  logic       pfdEnable,
  input  logic       flagAck,
  output logic       tmrFlag,
  output logic       irqReq,
  output logic       pfdOut
);
  localparam int DW = 8;
  localparam int AW = 3;

  strobe_t          stb;
  logic [DW-1:0]    ctrlRd;
  logic [CNT_W-1:0] cntQ, plQ;
  logic             cntAtMax, pfdTgl;

  evt_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES), .AW(AW), .DW(DW)) u_ctrl (
    .clk, .rstN, .busWe, .busRe, .busAddr, .busWdata,
    .sysTick, .div4Tick, .rtcTick, .adcTick, .extIn,
    .cntAtMax, .stb, .ctrlRd
  );

  evt_timer_dp #(.CNT_W(CNT_W), .DW(DW)) u_dp (
    .clk, .rstN, .stb, .wrByte(busWdata), .flagAck,
    .cntQ, .plQ, .cntAtMax, .tmrFlag, .pfdTgl
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL:   busRdata = ctrlRd;
      ADDR_PL_LO:  busRdata = plQ[DW-1:0];
      ADDR_PL_HI:  busRdata = plQ[CNT_W-1:DW];
      ADDR_CNT_LO: busRdata = cntQ[DW-1:0];
      ADDR_CNT_HI: busRdata = cntQ[CNT_W-1:DW];
      default:     busRdata = '0;
    endcase
  end

  assign irqReq = tmrFlag & irqEnable;
  assign pfdOut = pfdTgl & pfdEnable;

  AST_HIREAD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_CNT_HI && !busWe) |=> $stable(cntQ)); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> irqEnable); // R9
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  import evt_timer_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 0, busRe = 0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic sysTick = 0, div4Tick = 0, rtcTick = 0, adcTick = 0, extIn = 0;
  logic irqEnable = 1, pfdEnable = 1, flagAck = 0;
  logic tmrFlag, irqReq, pfdOut;

  always #2.5 clk = ~clk;

  evt_timer u0 (
    .clk, .rstN, .busWe, .busRe, .busAddr, .busWdata, .busRdata,
    .sysTick, .div4Tick, .rtcTick, .adcTick, .extIn,
    .irqEnable, .pfdEnable, .flagAck, .tmrFlag, .irqReq, .pfdOut
  );

  typedef struct {
    bit         isRead;
    logic [2:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t expQ[$];
  logic  chkStb = 0;
  int    vectors = 0, misses = 0;
  bit    finished = 0;

  // monitor: compares on the falling edge of each checked cycle
  always @(negedge clk) begin
    if (chkStb) begin
      item_t it;
      logic [7:0] act;
      it  = expQ.pop_front();
      act = it.isRead ? busRdata : {5'b0, tmrFlag, irqReq, pfdOut};
      vectors++;
      if (act !== it.exp) begin
        misses++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 0;
  endtask

  task automatic chk(input bit rd, input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.isRead = rd; it.addr = a; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    busRe = rd; busAddr = a; chkStb = 1;
    @(posedge clk); #1;
    busRe = 0; chkStb = 0;
  endtask

  task automatic chkCnt(input logic [15:0] e, input string tag);
    chk(1, ADDR_CNT_LO, e[7:0], tag);
    chk(1, ADDR_CNT_HI, e[15:8], tag);
  endtask

  task automatic chkStat(input logic [2:0] e, input string tag);
    chk(0, 3'd0, {5'b0, e}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int which, input int n);
    case (which)
      0: sysTick = 1; 1: div4Tick = 1; 2: rtcTick = 1; 3: adcTick = 1; default: flagAck = 1;
    endcase
    repeat (n) @(posedge clk);
    #1;
    sysTick = 0; div4Tick = 0; rtcTick = 0; adcTick = 0; flagAck = 0;
  endtask

  task automatic ext(input logic v);
    extIn = v;
    idle(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    // R1 reset state
    chkCnt(16'h0000, "R1 count");
    chk(1, ADDR_CTRL, 8'h00, "R1 ctrl");
    chk(1, ADDR_PL_HI, 8'h00, "R1 reload");
    chkStat(3'b000, "R1 outputs");

    // R5 stopped write loads count; R3/R4 wrap
    wr(ADDR_PL_LO, 8'hFE); wr(ADDR_PL_HI, 8'hFF);
    chkCnt(16'hFFFE, "R5 stopped load");
    wr(ADDR_CTRL, 8'h10);
    pulse(0, 1); chkCnt(16'hFFFF, "R3 sys step");
    pulse(0, 1); chkCnt(16'hFFFE, "R4 reload on wrap");
    chkStat(3'b111, "R4 R9 R10 flag irq pfd");
    pulse(4, 1); chkStat(3'b001, "R4 flag ack");
    irqEnable = 0; pfdEnable = 0;
    pulse(0, 2); chkStat(3'b100, "R9 R10 gated");
    pfdEnable = 1; chkStat(3'b100, "R10 divider state");
    pulse(0, 2); chkStat(3'b101, "R10 toggle");

    wr(ADDR_PL_LO, 8'h34); wr(ADDR_PL_HI, 8'h12);
    chkCnt(16'hFFFE, "R5 running write");
    pulse(0, 2); chkCnt(16'h1234, "R5 new reload");

    wr(ADDR_CTRL, 8'h00);
    pulse(0, 3); chkCnt(16'h1234, "R3 run off");

    wr(ADDR_CTRL, 8'hFF);
    chk(1, ADDR_CTRL, 8'hF8, "R2 low bits zero");
    pulse(0, 2); pulse(1, 2); pulse(2, 2); pulse(3, 2);
    ext(1); ext(0);
    chkCnt(16'h1234, "R3 unused mode");

    wr(ADDR_CTRL, 8'h30);
    pulse(0, 3); chkCnt(16'h1234, "R3 div4 ignores sys");
    pulse(1, 2); chkCnt(16'h1236, "R3 div4");
    wr(ADDR_CTRL, 8'h50);
    pulse(2, 1); pulse(0, 1); chkCnt(16'h1237, "R3 rtc");
    wr(ADDR_CTRL, 8'h70);
    pulse(3, 1); chkCnt(16'h1238, "R3 adc");

    wr(ADDR_CTRL, 8'h90);
    ext(1); chkCnt(16'h1239, "R6 rising");
    ext(0); chkCnt(16'h1239, "R6 falling ignored");
    ext(1); chkCnt(16'h123A, "R6 rising again");
    wr(ADDR_CTRL, 8'h98);
    ext(0); chkCnt(16'h123B, "R6 falling active");
    ext(1); chkCnt(16'h123B, "R6 rising ignored");

    // R12 latency
    wr(ADDR_CTRL, 8'h90);
    ext(0);
    extIn = 1;
    idle(1);
    chk(1, ADDR_CNT_LO, 8'h3B, "R12 edge k");
    chk(1, ADDR_CNT_LO, 8'h3B, "R12 edge k+1");
    chk(1, ADDR_CNT_LO, 8'h3C, "R12 edge k+2");

    // R7 R8 capture
    wr(ADDR_CTRL, 8'h00);
    wr(ADDR_PL_LO, 8'h00); wr(ADDR_PL_HI, 8'h00);
    chkCnt(16'h0000, "R5 clear");
    div4Tick = 1;
    wr(ADDR_CTRL, 8'hB8);
    extIn = 0; idle(5); extIn = 1; idle(4);
    chkCnt(16'h0005, "R7 width");
    chk(1, ADDR_CTRL, 8'hA8, "R7 run cleared");
    extIn = 0; idle(3); extIn = 1; idle(4);
    chkCnt(16'h0005, "R8 held after capture");
    ext(0);
    wr(ADDR_CTRL, 8'hB8);
    idle(6); chkCnt(16'h0005, "R8 level does not start");
    ext(1); chkCnt(16'h0005, "R8 return edge while waiting");
    extIn = 0; idle(2); extIn = 1; idle(4);
    chkCnt(16'h0007, "R7 second capture");
    div4Tick = 0;

    // R11 high-byte read blocks a step
    wr(ADDR_CTRL, 8'h00);
    wr(ADDR_PL_LO, 8'h10); wr(ADDR_PL_HI, 8'h00);
    sysTick = 1;
    wr(ADDR_CTRL, 8'h10);
    chk(1, ADDR_CNT_HI, 8'h00, "R11 hi read");
    chk(1, ADDR_CNT_LO, 8'h10, "R11 blocked step");
    chk(1, ADDR_CNT_LO, 8'h11, "R11 resumes");
    sysTick = 0;
    chk(1, ADDR_CNT_LO, 8'h12, "R11 final");

    idle(2);
    if (expQ.size() != 0) begin
      misses++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule